// File: doc/BRIEF.md
# Serial Register Bus Master Engine

This block is the host side of a slow three-wire register bus. It takes one register read or write request and turns it into the pin waveform the target expects: a bus clock, an enable and a host-to-target data line, with a separate target-to-host data line for read results. It also handles the target's ready indication, and it can ask for the target to be reset when that indication does not come.

Before every transfer the engine drives all three outgoing wires low. It then waits for the target to signal ready. Each wait has a cycle budget. A wait that runs out pulses a reset request to the target and starts a new wait. After a fixed number of failed waits the request ends with an error.

Once the target is ready, the engine raises the enable and shifts out the payload. A read sends only the address. A write sends the data and then the address. The engine then drops the enable and clocks a direction bit. For a read it clocks in 32 result bits. The request side uses a valid/ready handshake, and a one-cycle done pulse returns the read data and the error flag. Each clock phase lasts a set number of system-clock cycles.

Top module: `serial_reg_master`

## Requirements
- R1: Out of reset the engine is idle. `req_ready` is 1, and `ser_clk`, `ser_en`, `ser_out`, `done` and `tgt_reset` are all 0.
- R2: When a request is accepted, `ser_clk`, `ser_en` and `ser_out` go low and stay low while the engine waits for `tgt_ready`. Each wait attempt lasts `RDY_TIMEOUT` cycles. A `tgt_ready` seen in the last cycle of an attempt still starts the transfer, with no reset pulse for that attempt.
- R3: Every attempt that ends without `tgt_ready` produces one `tgt_reset` pulse of `RST_CYC` cycles, with all outgoing wires low. After `RDY_TRIES` failed attempts the request completes with `done_err`=1, `done_rdata`=0 and no bus clock edge.
- R4: A transfer raises `ser_en` while `ser_clk` is low. Each bit is placed on `ser_out` in the same cycle that `ser_clk` falls. The clock then stays low for `HALF_CYC` cycles and high for `HALF_CYC` cycles, so the target samples on the rising edge.
- R5: A read (`req_write`=0) sends the 3 address bits, most significant bit first, with `ser_en`=1. A write (`req_write`=1) sends the 32 data bits MSB first and then the 3 address bits MSB first, all with `ser_en`=1.
- R6: After the payload, one direction bit is clocked with `ser_en`=0. Its value is 0 for a read and 1 for a write. After that bit, `ser_out` stays 0.
- R7: A read then issues 32 more clock pulses with `ser_en`=0 and `ser_out`=0. `ser_in` is sampled at the end of each high phase, and the first sample becomes bit 31 of `done_rdata`.
- R8: `done` is high for exactly one cycle. On success `done_err`=0 and `done_rdata` holds the read value, or 0 for a write. `done_err` is never 1 without `done`.
- R9: `req_ready` is 1 only while idle. This includes the cycle in which `done` is high, so a new request can be accepted back to back. `req_ready` drops in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Target register address |
| req_wdata | input | DATA_W | Write value |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | DATA_W | Read result, valid with done |
| done_err | output | 1 | Ready wait exhausted, valid with done |
| tgt_reset | output | 1 | Reset request pulse to the target |
| ser_clk | output | 1 | Serial bus clock |
| ser_en | output | 1 | Serial bus enable |
| ser_out | output | 1 | Host-to-target data |
| ser_in | input | 1 | Target-to-host data (synchronous to clk) |
| tgt_ready | input | 1 | Target ready indication (synchronous to clk) |

## Verification
Two events can land on the same cycle in this block.

The first pair is ready and timeout. The bench raises `tgt_ready` exactly in the last cycle of the second wait attempt, counting from the falling edge of the first `tgt_reset` pulse. It expects the transfer to start with only one reset pulse. One cycle later it expects a second pulse before the start.

The second pair is completion and the next request. The bench presents a new request in the very cycle `done` is high. It judges that `req_ready` is 1 there and 0 a cycle later. It then checks that the second transfer's bit stream is complete.

A queue-based model of the target compares every rising-edge bit, each clock-phase length and the line levels on every clock.

// File: rtl/sbm_pkg.sv
// Shared types for the serial register bus master.
package sbm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_PREP, ST_WAIT, ST_TRST, ST_EN, ST_BLO, ST_BHI
    } sbm_state_e;

    typedef enum logic [1:0] {
        PH_PAY, PH_DIR, PH_RX
    } sbm_phase_e;
endpackage

// File: rtl/sbm_timer.sv
// Loadable down-counter that times clock phases, wait windows and reset pulses.
// Assumes load_val fits in W bits; zero is high while the count is exhausted.
module sbm_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Count down to zero and hold there unless reloaded.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R4: a running count falls by exactly one per cycle, giving fixed phase lengths
    p_tmr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/sbm_shifter.sv
// Transmit shift register (MSB out first) and receive shift register (first bit
// ends up as MSB). Assumes TXW >= 2 and that load and shift are never requested together.
module sbm_shifter #(
    parameter int TXW = 35,
    parameter int RXW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tx_load,
    input  logic [TXW-1:0] tx_val,
    input  logic           tx_shift,
    output logic           tx_msb,
    output logic           tx_next,
    input  logic           rx_clr,
    input  logic           rx_shift,
    input  logic           rx_bit,
    output logic [RXW-1:0] rx_data
);
    logic [TXW-1:0] tx_q;

    // Hold the outgoing bit string and move it towards the MSB end.
    always_ff @(posedge clk) begin
        if (!rst_n)        tx_q <= '0;
        else if (tx_load)  tx_q <= tx_val;
        else if (tx_shift) tx_q <= {tx_q[TXW-2:0], 1'b0};
    end

    // Collect incoming bits, the earliest landing in the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_data <= '0;
        else if (rx_clr)   rx_data <= '0;
        else if (rx_shift) rx_data <= {rx_data[RXW-2:0], rx_bit};
    end

    assign tx_msb  = tx_q[TXW-1];
    assign tx_next = tx_q[TXW-2];

    // R5: the controller never loads and shifts the payload in one cycle
    p_load_shift_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_load && tx_shift));
endmodule

// File: rtl/serial_reg_master.sv
// Serial register bus master: turns one read/write request into the
// clock/enable/data waveform of a three-wire register bus.
// Assumes ser_in and tgt_ready are already synchronous to clk, HALF_CYC >= 1,
// RDY_TIMEOUT >= 1 and RST_CYC >= 1. Request fields are sampled at acceptance only.
module serial_reg_master
    import sbm_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 32,
    parameter int HALF_CYC    = 250,
    parameter int RDY_TIMEOUT = 1000,
    parameter int RDY_TRIES   = 3,
    parameter int RST_CYC     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic [DATA_W-1:0] done_rdata,
    output logic              done_err,
    output logic              tgt_reset,
    output logic              ser_clk,
    output logic              ser_en,
    output logic              ser_out,
    input  logic              ser_in,
    input  logic              tgt_ready
);
    localparam int TXW  = DATA_W + ADDR_W;
    localparam int CW   = $clog2(TXW + 1);
    localparam int TRW  = $clog2(RDY_TRIES + 1);
    localparam int TM1  = (HALF_CYC > RDY_TIMEOUT) ? HALF_CYC : RDY_TIMEOUT;
    localparam int TMAX = (TM1 > RST_CYC) ? TM1 : RST_CYC;
    localparam int TW   = $clog2(TMAX + 1);

    localparam logic [TW-1:0] T_HALF = TW'(HALF_CYC - 1);
    localparam logic [TW-1:0] T_WAIT = TW'(RDY_TIMEOUT - 1);
    localparam logic [TW-1:0] T_RST  = TW'(RST_CYC - 1);

    sbm_state_e       st, st_n;
    sbm_phase_e       ph, ph_n;
    logic [CW-1:0]    bits, bits_n;
    logic [TRW-1:0]   tries, tries_n;
    logic             clk_q, clk_n, en_q, en_n, di_q, di_n;
    logic             wr_q, wr_n, done_q, done_n, err_q, err_n;

    logic             tmr_load, tmr_zero;
    logic [TW-1:0]    tmr_val;
    logic             tx_load, tx_shift, tx_msb, tx_next, rx_clr, rx_shift;
    logic [TXW-1:0]   tx_val;
    logic [DATA_W-1:0] rx_data;

    sbm_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    sbm_shifter #(.TXW(TXW), .RXW(DATA_W)) u_shifter (
        .clk(clk), .rst_n(rst_n),
        .tx_load(tx_load), .tx_val(tx_val), .tx_shift(tx_shift),
        .tx_msb(tx_msb), .tx_next(tx_next),
        .rx_clr(rx_clr), .rx_shift(rx_shift), .rx_bit(ser_in), .rx_data(rx_data)
    );

    // Sequence decisions: next state, next pin levels and datapath strobes.
    always_comb begin
        st_n = st;  ph_n = ph;  bits_n = bits;  tries_n = tries;
        clk_n = clk_q;  en_n = en_q;  di_n = di_q;  wr_n = wr_q;
        done_n = 1'b0;  err_n = 1'b0;
        tmr_load = 1'b0;  tmr_val = '0;
        tx_load = 1'b0;  tx_val = '0;  tx_shift = 1'b0;
        rx_clr = 1'b0;  rx_shift = 1'b0;
        unique case (st)
            ST_IDLE: if (req_valid) begin
                wr_n    = req_write;
                tx_load = 1'b1;
                tx_val  = req_write ? {req_wdata, req_addr} : {req_addr, {DATA_W{1'b0}}};
                bits_n  = req_write ? CW'(TXW) : CW'(ADDR_W);
                clk_n = 1'b0;  en_n = 1'b0;  di_n = 1'b0;
                tries_n = '0;
                rx_clr  = 1'b1;
                st_n    = ST_PREP;
            end
            ST_PREP: begin
                tmr_load = 1'b1;  tmr_val = T_WAIT;  st_n = ST_WAIT;
            end
            ST_WAIT: if (tgt_ready) begin
                en_n = 1'b1;  ph_n = PH_PAY;  st_n = ST_EN;
            end else if (tmr_zero) begin
                tries_n  = tries + 1'b1;
                tmr_load = 1'b1;  tmr_val = T_RST;  st_n = ST_TRST;
            end
            ST_TRST: if (tmr_zero) begin
                if (tries == TRW'(RDY_TRIES)) begin
                    done_n = 1'b1;  err_n = 1'b1;  st_n = ST_IDLE;
                end else begin
                    tmr_load = 1'b1;  tmr_val = T_WAIT;  st_n = ST_WAIT;
                end
            end
            ST_EN: begin
                di_n = tx_msb;  clk_n = 1'b0;
                tmr_load = 1'b1;  tmr_val = T_HALF;  st_n = ST_BLO;
            end
            ST_BLO: if (tmr_zero) begin
                clk_n = 1'b1;
                tmr_load = 1'b1;  tmr_val = T_HALF;  st_n = ST_BHI;
            end
            ST_BHI: if (tmr_zero) begin
                unique case (ph)
                    PH_PAY: begin
                        tx_shift = 1'b1;
                        bits_n   = bits - 1'b1;
                        clk_n    = 1'b0;
                        tmr_load = 1'b1;  tmr_val = T_HALF;  st_n = ST_BLO;
                        if (bits == CW'(1)) begin
                            ph_n = PH_DIR;  en_n = 1'b0;  di_n = wr_q;
                        end else begin
                            di_n = tx_next;
                        end
                    end
                    PH_DIR: begin
                        di_n = 1'b0;
                        if (wr_q) begin
                            done_n = 1'b1;  st_n = ST_IDLE;
                        end else begin
                            ph_n = PH_RX;  bits_n = CW'(DATA_W);  clk_n = 1'b0;
                            tmr_load = 1'b1;  tmr_val = T_HALF;  st_n = ST_BLO;
                        end
                    end
                    PH_RX: begin
                        rx_shift = 1'b1;
                        bits_n   = bits - 1'b1;
                        if (bits == CW'(1)) begin
                            done_n = 1'b1;  st_n = ST_IDLE;
                        end else begin
                            clk_n = 1'b0;
                            tmr_load = 1'b1;  tmr_val = T_HALF;  st_n = ST_BLO;
                        end
                    end
                    default: st_n = ST_IDLE;
                endcase
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // Register the sequence state and every pin level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;  ph <= PH_PAY;  bits <= '0;  tries <= '0;
            clk_q <= 1'b0;  en_q <= 1'b0;  di_q <= 1'b0;
            wr_q <= 1'b0;  done_q <= 1'b0;  err_q <= 1'b0;
        end else begin
            st <= st_n;  ph <= ph_n;  bits <= bits_n;  tries <= tries_n;
            clk_q <= clk_n;  en_q <= en_n;  di_q <= di_n;
            wr_q <= wr_n;  done_q <= done_n;  err_q <= err_n;
        end
    end

    assign req_ready  = (st == ST_IDLE);
    assign tgt_reset  = (st == ST_TRST);
    assign ser_clk    = clk_q;
    assign ser_en     = en_q;
    assign ser_out    = di_q;
    assign done       = done_q;
    assign done_err   = err_q;
    assign done_rdata = rx_data;

    // R2: no bus activity while waiting for the target
    p_quiet_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) |-> (!ser_clk && !ser_en && !ser_out));
    // R3: reset request only with all outgoing wires low
    p_rst_lines_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_reset |-> (!ser_clk && !ser_en && !ser_out));
    // R3: attempt count never passes its limit
    p_tries_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tries <= TRW'(RDY_TRIES));
    // R4: enable rises only while the bus clock is low
    p_en_rise_clk_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_en) |-> !ser_clk);
    // R8: completion is a single-cycle pulse
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: error flag only with completion
    p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_err |-> done);
    // R9: completion cycle already accepts the next request
    p_done_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);
endmodule

// File: tb/serial_reg_master_bench.sv
module serial_reg_master_bench;
    localparam int HALF  = 3;
    localparam int TO    = 12;
    localparam int RSTC  = 2;
    localparam int TRIES = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, done, done_err, tgt_reset, ser_clk, ser_en, ser_out;
    logic [31:0] done_rdata;
    logic        ser_in = 1'b0, tgt_ready = 1'b0;

    always #5 clk = ~clk;

    serial_reg_master #(
        .ADDR_W(3), .DATA_W(32), .HALF_CYC(HALF), .RDY_TIMEOUT(TO),
        .RDY_TRIES(TRIES), .RST_CYC(RSTC)
    ) u_serial_reg_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .done_rdata(done_rdata), .done_err(done_err),
        .tgt_reset(tgt_reset), .ser_clk(ser_clk), .ser_en(ser_en), .ser_out(ser_out),
        .ser_in(ser_in), .tgt_ready(tgt_ready)
    );

    int n_chk = 0, n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Target model state, updated once per clock away from the active edge.
    bit          cap_en[$];
    bit          cap_di[$];
    int          rst_pulses, hp_bad, line_bad, cyc;
    bit          prev_clk, prev_en, prev_rst, rise_ok, fall_ok;
    bit          rx_armed, rx_on;
    int          rx_k;
    logic [31:0] rd_val;
    int          rdy_mode, rdy_off, rdy_cd;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (ser_clk && !prev_clk) begin
                cap_en.push_back(ser_en);
                cap_di.push_back(ser_out);
                if (fall_ok && cyc != HALF) hp_bad++;
                fall_ok = 1'b0; rise_ok = 1'b1; cyc = 0;
                if (rx_armed && !rx_on && !ser_en) begin rx_on = 1'b1; rx_k = 0; end
            end else if (!ser_clk && prev_clk) begin
                if (rise_ok && cyc != HALF) hp_bad++;
                fall_ok = rise_ok; rise_ok = 1'b0; cyc = 0;
                if (rx_on && rx_k < 32) begin ser_in = rd_val[31 - rx_k]; rx_k++; end
            end
            if (ser_en && !prev_en && (ser_clk || ser_out)) line_bad++;
            if (tgt_reset && (ser_clk || ser_en || ser_out)) line_bad++;
            if (tgt_reset && !prev_rst) rst_pulses++;
            if (!tgt_reset && prev_rst && rdy_mode == 1 && !tgt_ready) begin
                if (rdy_off == 0) tgt_ready = 1'b1;
                else rdy_cd = rdy_off;
            end else if (rdy_cd > 0) begin
                rdy_cd--;
                if (rdy_cd == 0) tgt_ready = 1'b1;
            end
            prev_clk = ser_clk; prev_en = ser_en; prev_rst = tgt_reset;
        end
    end

    // One request, entered at a falling clock edge; returns in the done cycle.
    // mode 0: target ready at once; 1: ready 'off' cycles after the first reset ends; 2: never ready.
    task automatic xfer(input bit wr, input logic [2:0] addr, input logic [31:0] wd,
                        input logic [31:0] rv, input int mode, input int off,
                        input int exp_rst, input bit exp_err, input string tag);
        bit          exp_en[$];
        bit          exp_di[$];
        logic [34:0] pv;
        logic [31:0] got_rd, exp_rd;
        bit          got_err;
        int          bad;
        cap_en.delete(); cap_di.delete();
        rst_pulses = 0; hp_bad = 0; line_bad = 0; rise_ok = 1'b0; fall_ok = 1'b0;
        rx_armed = !wr; rx_on = 1'b0; rd_val = rv; ser_in = 1'b0;
        rdy_mode = mode; rdy_off = off; rdy_cd = 0; tgt_ready = (mode == 0);
        check(req_ready == 1'b1, "R9", {tag, " ready before request"}, req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R9", {tag, " ready drops after accept"}, req_ready, 0);
        while (!done) @(negedge clk);
        got_rd = done_rdata; got_err = done_err;

        if (!exp_err) begin
            pv = {wd, addr};
            for (int i = 0; i < (wr ? 35 : 3); i++) begin
                exp_en.push_back(1'b1);
                exp_di.push_back(wr ? pv[34 - i] : addr[2 - i]);
            end
            exp_en.push_back(1'b0); exp_di.push_back(wr);
            if (!wr) for (int i = 0; i < 32; i++) begin
                exp_en.push_back(1'b0); exp_di.push_back(1'b0);
            end
        end
        check(cap_en.size() == exp_en.size(), "R5", {tag, " pulse count"},
              cap_en.size(), exp_en.size());
        if (cap_en.size() == exp_en.size() && !exp_err) begin
            bad = 0;
            for (int i = 0; i < (wr ? 35 : 3); i++)
                if (cap_en[i] != exp_en[i] || cap_di[i] != exp_di[i]) bad++;
            check(bad == 0, "R5", {tag, " payload bit errors"}, bad, 0);
            check(cap_en[wr ? 35 : 3] == 1'b0 && cap_di[wr ? 35 : 3] == wr, "R6",
                  {tag, " direction bit {en,di}"},
                  {cap_en[wr ? 35 : 3], cap_di[wr ? 35 : 3]}, {1'b0, wr});
            if (!wr) begin
                bad = 0;
                for (int i = 4; i < 36; i++) if (cap_en[i] || cap_di[i]) bad++;
                check(bad == 0, "R7", {tag, " receive pulses with lines low"}, bad, 0);
            end
        end
        exp_rd = (wr || exp_err) ? 32'h0 : rv;
        check(got_rd == exp_rd, wr ? "R8" : "R7", {tag, " read data"}, got_rd, exp_rd);
        check(got_err == exp_err, exp_err ? "R3" : "R8", {tag, " error flag"}, got_err, exp_err);
        check(rst_pulses == exp_rst, exp_err ? "R3" : "R2", {tag, " reset pulses"},
              rst_pulses, exp_rst);
        check(hp_bad == 0, "R4", {tag, " phase length errors"}, hp_bad, 0);
        check(line_bad == 0, "R2", {tag, " lines high at start or reset"}, line_bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle levels after reset
        check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        check({ser_clk, ser_en, ser_out} == 3'b000, "R1", "bus lines after reset",
              {ser_clk, ser_en, ser_out}, 0);
        check(done == 1'b0 && tgt_reset == 1'b0, "R1", "done/reset after reset",
              {done, tgt_reset}, 0);

        xfer(1'b1, 3'd5, 32'hA5C3_0F81, 32'h0, 0, 0, 0, 1'b0, "write basic");
        @(negedge clk);
        check(done == 1'b0, "R8", "done lasts one cycle", done, 0);
        xfer(1'b0, 3'd3, 32'h0, 32'h8000_0001, 0, 0, 0, 1'b0, "read edge bits");
        xfer(1'b0, 3'd6, 32'h0, 32'h5A5A_F00F, 0, 0, 0, 1'b0, "read mixed");
        // R2: ready in the final cycle of attempt two wins over its timeout
        xfer(1'b0, 3'd1, 32'h0, 32'h1234_5678, 1, TO - 1, 1, 1'b0, "ready last cycle");
        // R2: ready one cycle too late costs another reset
        xfer(1'b1, 3'd2, 32'h0000_0001, 32'h0, 1, TO, 2, 1'b0, "ready one late");
        // R3: never ready -> error after all attempts
        xfer(1'b0, 3'd7, 32'h0, 32'hDEAD_BEEF, 2, 0, TRIES, 1'b1, "timeout");
        // R9: back-to-back, second request presented in the done cycle
        xfer(1'b1, 3'd4, 32'hFFFF_0000, 32'h0, 0, 0, 0, 1'b0, "b2b first");
        xfer(1'b0, 3'd0, 32'h0, 32'hC0FF_EE11, 0, 0, 0, 1'b0, "b2b second");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule